// File: doc/BRIEF.md
# Discharge Short-Circuit Protection Sequencer

This block decides when a battery's discharge switch must be held off after short-circuit events. An external comparator reports overcurrent on each fast sample strobe. Once enough consecutive overcurrent samples have been seen, the block trips and asserts its discharge-disable output. Each trip also raises a fault count. That count drains by one per configured number of seconds. If the count reaches a configured limit, the fault becomes a latched lockout instead of a plain trip.

A plain trip clears after a configured number of seconds. It also clears at once when load detection is enabled and the load has gone away. A lockout clears only after its own reset time. The threshold code in the packed configuration byte is passed straight to the analog front end. All timing runs from a one-cycle 1 Hz tick.

Top module: `dsg_short_guard`

## Requirements
- R1: While reset is high and in the cycle after it is released, `trip`, `latched`, `alert` and `dsg_off` are low.
- R2: `thr_code` always equals bits [2:0] of `cfg_thr_dly`.
- R3: A trip needs N consecutive samples with `oc_hit` high, where N is bits [7:4] of `cfg_thr_dly` plus one, so N ranges from 1 to 16. Only cycles with `sample_stb` high count as samples. A sample with `oc_hit` low restarts the count.
- R4: On the clock edge that takes the Nth qualifying sample, `trip` and `dsg_off` go high, the fault count rises by one and `alert` goes high.
- R5: If `cfg_latch_lim` is nonzero and the incremented fault count is at least `cfg_latch_lim`, then `latched` goes high instead of `trip`, and `dsg_off` goes high.
- R6: A trip clears on the `sec_tick` that brings the number of ticks seen during the trip to `cfg_recover_s`. A value of 0 is treated as 1.
- R7: While tripped, `load_det_en` high together with `load_present` low clears the trip on the next edge. This has no effect on a lockout.
- R8: A lockout clears on the `sec_tick` that brings the number of ticks seen during the lockout to `cfg_reset_s`. A value of 0 is treated as 1. `dsg_off` then falls.
- R9: While the fault count is nonzero, `alert` is high and the count drops by one every `cfg_dec_period` ticks, with 0 treated as 1. The period starts counting when the count leaves zero. `alert` falls when the count reaches zero. An increment in the same cycle as a decrement wins.
- R10: The fault count saturates at 255. With `cfg_latch_lim` = 0 no lockout ever occurs.
- R11: While `dsg_off` is high, overcurrent samples are not counted. Qualification restarts from zero after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | Fast sample strobe |
| oc_hit | input | 1 | Overcurrent seen at this sample |
| load_present | input | 1 | Load still attached |
| load_det_en | input | 1 | Enables early recovery on load removal |
| sec_tick | input | 1 | One-cycle 1 Hz tick |
| cfg_thr_dly | input | 8 | [2:0] threshold code, [7:4] delay code |
| cfg_latch_lim | input | 8 | Fault count that causes lockout (0 = never) |
| cfg_dec_period | input | 8 | Seconds per fault-count decrement |
| cfg_recover_s | input | 8 | Trip recovery time in seconds |
| cfg_reset_s | input | 8 | Lockout reset time in seconds |
| thr_code | output | 3 | Threshold code for the comparator |
| alert | output | 1 | Fault count nonzero |
| trip | output | 1 | Short-circuit trip active |
| latched | output | 1 | Lockout active |
| dsg_off | output | 1 | Discharge switch disable |

## Verification
Qualification is driven with oc patterns stored in a table. The patterns are a single hit, an exact run, a run broken by a gap, a run that starts late, and runs of 15 and 16 at the longest delay. Together they separate "consecutive" from "cumulative" counting and show an off-by-one in the delay mapping. Directed sequences then set the timer-driven release paths against the early load-removal path. Two sequences check that a lockout ignores load removal and that the count leaks away at the configured rate. A run of 256 trips with latching disabled shows whether the count saturates or wraps. The last sequence shows that samples taken while the switch is off are discarded.

// File: rtl/dsg_short_pkg.sv
package dsg_short_pkg;

    localparam int CFG_W  = 8;
    localparam int CNT_W  = 8;
    localparam int DLY_W  = 4;
    localparam int QCNT_W = DLY_W + 1;

    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_TRIP  = 2'd1,
        ST_LOCK  = 2'd2
    } prot_state_e;

    typedef struct packed {
        logic [DLY_W-1:0] dly_code;
        logic             spare;
        logic [2:0]       thr_code;
    } thr_dly_t;

    // Number of consecutive samples needed for a trip.
    function automatic logic [QCNT_W-1:0] qual_need(input logic [DLY_W-1:0] code);
        return {1'b0, code} + QCNT_W'(1);
    endfunction

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == {CNT_W{1'b1}}) ? v : v + CNT_W'(1);
    endfunction

endpackage

// File: rtl/dsg_short_sectmr.sv
module dsg_short_sectmr #(
    parameter int W = dsg_short_pkg::CFG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;
    logic [W-1:0] lim_eff;
    logic [W:0]   nxt;

    assign lim_eff = (limit == '0) ? W'(1) : limit;
    assign nxt     = {1'b0, cnt} + (W+1)'(1);
    assign done    = run && tick && (nxt >= {1'b0, lim_eff});

    // Restarts from zero whenever the timed state is not active.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= done ? '0 : nxt[W-1:0];
        end
    end
endmodule

// File: rtl/dsg_short_qual.sv
module dsg_short_qual
    import dsg_short_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             stb,
    input  logic             hit,
    input  logic [DLY_W-1:0] code,
    output logic             fire
);
    logic [QCNT_W-1:0] cnt;
    logic [QCNT_W:0]   nxt;

    assign nxt  = {1'b0, cnt} + (QCNT_W+1)'(1);
    assign fire = run && stb && hit && (nxt >= {1'b0, qual_need(code)});

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (stb) begin
            cnt <= (!hit || fire) ? '0 : nxt[QCNT_W-1:0];
        end
    end
endmodule

// File: rtl/dsg_short_leak.sv
module dsg_short_leak
    import dsg_short_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             tick,
    input  logic [CFG_W-1:0] period,
    output logic [CNT_W-1:0] count
);
    logic dec_due;

    dsg_short_sectmr #(.W(CFG_W)) u_dec_tmr (
        .clk   (clk),
        .rst   (rst),
        .run   (count != '0),
        .tick  (tick),
        .limit (period),
        .done  (dec_due)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc) begin
            count <= sat_inc(count);
        end else if (dec_due) begin
            count <= count - CNT_W'(1);
        end
    end
endmodule

// File: rtl/dsg_short_guard.sv
module dsg_short_guard
    import dsg_short_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_stb,
    input  logic             oc_hit,
    input  logic             load_present,
    input  logic             load_det_en,
    input  logic             sec_tick,
    input  logic [CFG_W-1:0] cfg_thr_dly,
    input  logic [CFG_W-1:0] cfg_latch_lim,
    input  logic [CFG_W-1:0] cfg_dec_period,
    input  logic [CFG_W-1:0] cfg_recover_s,
    input  logic [CFG_W-1:0] cfg_reset_s,
    output logic [2:0]       thr_code,
    output logic             alert,
    output logic             trip,
    output logic             latched,
    output logic             dsg_off
);
    thr_dly_t    cfg;
    prot_state_e st, st_nx;
    logic        qual_fire, rec_done, lock_done, load_gone, lock_now;
    logic        cfg_unused;
    logic [CNT_W-1:0] fault_cnt;

    assign cfg        = thr_dly_t'(cfg_thr_dly);
    assign cfg_unused = cfg.spare;
    assign thr_code   = cfg.thr_code;
    assign load_gone  = load_det_en && !load_present;
    assign lock_now   = (cfg_latch_lim != '0) && (sat_inc(fault_cnt) >= cfg_latch_lim);

    dsg_short_qual u_qual (
        .clk  (clk),
        .rst  (rst),
        .run  (st == ST_ARMED),
        .stb  (sample_stb),
        .hit  (oc_hit),
        .code (cfg.dly_code),
        .fire (qual_fire)
    );

    dsg_short_leak u_leak (
        .clk    (clk),
        .rst    (rst),
        .inc    (qual_fire),
        .tick   (sec_tick),
        .period (cfg_dec_period),
        .count  (fault_cnt)
    );

    dsg_short_sectmr #(.W(CFG_W)) u_rec_tmr (
        .clk   (clk),
        .rst   (rst),
        .run   (st == ST_TRIP),
        .tick  (sec_tick),
        .limit (cfg_recover_s),
        .done  (rec_done)
    );

    dsg_short_sectmr #(.W(CFG_W)) u_lock_tmr (
        .clk   (clk),
        .rst   (rst),
        .run   (st == ST_LOCK),
        .tick  (sec_tick),
        .limit (cfg_reset_s),
        .done  (lock_done)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_ARMED: if (qual_fire) st_nx = lock_now ? ST_LOCK : ST_TRIP;
            ST_TRIP:  if (rec_done || load_gone) st_nx = ST_ARMED;
            ST_LOCK:  if (lock_done) st_nx = ST_ARMED;
            default:  st_nx = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_ARMED;
        else     st <= st_nx;
    end

    assign trip    = (st == ST_TRIP);
    assign latched = (st == ST_LOCK);
    assign dsg_off = trip || latched;
    assign alert   = (fault_cnt != '0);
endmodule

// File: rtl/dsg_short_guard_chk.sv
module dsg_short_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       trip,
    input logic       latched,
    input logic       dsg_off,
    input logic       alert,
    input logic       load_det_en,
    input logic       load_present,
    input logic       sec_tick,
    input logic [7:0] cfg_latch_lim
);
    a_r4_trip_blocks_fet: assert property (@(posedge clk) disable iff (rst)
        trip |-> dsg_off);

    a_r5_lock_blocks_fet: assert property (@(posedge clk) disable iff (rst)
        latched |-> dsg_off);

    a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(trip && latched));

    a_r4_alert_on_trip: assert property (@(posedge clk) disable iff (rst)
        $rose(trip) |-> alert);

    a_r6_trip_holds: assert property (@(posedge clk) disable iff (rst)
        (trip && !sec_tick && !(load_det_en && !load_present)) |=> trip);

    a_r7_early_release: assert property (@(posedge clk) disable iff (rst)
        (trip && load_det_en && !load_present) |=> !trip);

    a_r8_lock_holds: assert property (@(posedge clk) disable iff (rst)
        (latched && !sec_tick) |=> latched);

    a_r10_no_lock_zero_limit: assert property (@(posedge clk) disable iff (rst)
        (cfg_latch_lim == 8'd0 && !latched) |=> !latched);
endmodule

bind dsg_short_guard dsg_short_guard_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .trip          (trip),
    .latched       (latched),
    .dsg_off       (dsg_off),
    .alert         (alert),
    .load_det_en   (load_det_en),
    .load_present  (load_present),
    .sec_tick      (sec_tick),
    .cfg_latch_lim (cfg_latch_lim)
);

// File: tb/dsg_short_guard_test.sv
module dsg_short_guard_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst = 1;
    logic sample_stb = 0, oc_hit = 0, load_present = 1, load_det_en = 0, sec_tick = 0;
    logic [7:0] cfg_thr_dly = 0, cfg_latch_lim = 0, cfg_dec_period = 10;
    logic [7:0] cfg_recover_s = 5, cfg_reset_s = 15;
    logic [2:0] thr_code;
    logic alert, trip, latched, dsg_off;

    int n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsg_short_guard uut (.*);

    // {delay code, oc pattern (bit i = sample i), index of tripping sample, 16 = none}
    localparam logic [24:0] QTAB [6] = '{
        {4'd0,  16'h0001, 5'd0},
        {4'd2,  16'h0007, 5'd2},
        {4'd2,  16'h003B, 5'd5},
        {4'd3,  16'h00F0, 5'd7},
        {4'd15, 16'hFFFF, 5'd15},
        {4'd15, 16'h7FFF, 5'd16}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; sample_stb = 0; oc_hit = 0; sec_tick = 0;
        load_present = 1; load_det_en = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic sample(input logic hit);
        @(negedge clk);
        sample_stb = 1; oc_hit = hit;
        @(posedge clk); #1;
        sample_stb = 0; oc_hit = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1;
        @(posedge clk); #1;
        sec_tick = 0;
    endtask

    task automatic load_recover();
        @(negedge clk);
        load_det_en = 1; load_present = 0;
        @(posedge clk); #1;
        load_det_en = 0; load_present = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        cfg_thr_dly = 8'hA5;
        @(posedge clk); #1;
        chk("R1 trip in reset", int'(trip), 0);
        chk("R1 dsg_off in reset", int'(dsg_off), 0);
        do_reset();
        @(posedge clk); #1;
        chk("R1 alert after reset", int'(alert), 0);
        chk("R1 latched after reset", int'(latched), 0);
        chk("R2 thr_code", int'(thr_code), 5);

        // R3/R4 qualification table
        foreach (QTAB[i]) begin
            int got;
            logic saw_alert;
            logic saw_off;
            do_reset();
            cfg_thr_dly = {QTAB[i][24:21], 4'h0};
            cfg_recover_s = 8'd200; cfg_latch_lim = 0; cfg_dec_period = 8'd200;
            got = 16; saw_alert = 0; saw_off = 0;
            for (int s = 0; s < 16; s++) begin
                sample(QTAB[i][5 + s]);
                if (trip && got == 16) begin
                    got = s; saw_alert = alert; saw_off = dsg_off;
                end
            end
            chk($sformatf("R3 trip sample vec%0d", i), got, int'(QTAB[i][4:0]));
            if (QTAB[i][4:0] != 5'd16) begin
                chk("R4 alert on trip", int'(saw_alert), 1);
                chk("R4 dsg_off on trip", int'(saw_off), 1);
            end
        end

        // R3 samples without strobe are ignored
        do_reset();
        cfg_thr_dly = 8'h00;
        @(negedge clk); oc_hit = 1;
        repeat (5) @(posedge clk);
        #1; chk("R3 no strobe no trip", int'(trip), 0);
        oc_hit = 0;

        // R6 timed recovery
        do_reset();
        cfg_recover_s = 8'd3; cfg_dec_period = 8'd200;
        sample(1);
        tick(); tick();
        chk("R6 trip held after 2 ticks", int'(trip), 1);
        tick();
        chk("R6 trip clears after 3 ticks", int'(trip), 0);
        chk("R6 dsg_off released", int'(dsg_off), 0);

        // R7 early recovery, and no effect when detection disabled
        do_reset();
        cfg_recover_s = 8'd200;
        sample(1);
        @(negedge clk); load_present = 0;
        repeat (3) @(posedge clk); #1;
        chk("R7 load low without enable keeps trip", int'(trip), 1);
        load_present = 1;
        load_recover();
        chk("R7 early recovery", int'(trip), 0);

        // R5 lockout and R8 lockout reset
        do_reset();
        cfg_latch_lim = 8'd2; cfg_reset_s = 8'd4; cfg_recover_s = 8'd200;
        sample(1);
        chk("R5 first trip not latched", int'(latched), 0);
        load_recover();
        sample(1);
        chk("R5 latched on limit", int'(latched), 1);
        chk("R5 trip clear when latched", int'(trip), 0);
        chk("R5 dsg_off when latched", int'(dsg_off), 1);
        load_recover();
        chk("R7 load removal keeps lockout", int'(latched), 1);
        tick(); tick(); tick();
        chk("R8 lockout held after 3 ticks", int'(latched), 1);
        tick();
        chk("R8 lockout cleared", int'(latched), 0);
        chk("R8 dsg_off released", int'(dsg_off), 0);

        // R9 leak of the fault count
        do_reset();
        cfg_latch_lim = 0; cfg_dec_period = 8'd3; cfg_recover_s = 8'd200;
        sample(1);
        load_recover();
        tick(); tick();
        chk("R9 alert held before period", int'(alert), 1);
        tick();
        chk("R9 alert cleared at zero", int'(alert), 0);

        // R10 saturation with latching disabled
        begin
            logic saw_lock;
            do_reset();
            cfg_latch_lim = 0; cfg_dec_period = 8'd255; cfg_recover_s = 8'd200;
            saw_lock = 0;
            for (int k = 0; k < 256; k++) begin
                sample(1);
                if (latched) saw_lock = 1;
                load_recover();
            end
            chk("R10 zero limit never latches", int'(saw_lock), 0);
            cfg_dec_period = 8'd1;
            for (int k = 0; k < 254; k++) tick();
            chk("R10 count saturated at 255", int'(alert), 1);
            tick();
            chk("R10 count drains to zero", int'(alert), 0);
        end

        // R11 samples ignored while switch off
        do_reset();
        cfg_thr_dly = 8'h20; cfg_recover_s = 8'd200; cfg_dec_period = 8'd200;
        sample(1); sample(1); sample(1);
        chk("R11 trip after 3 samples", int'(trip), 1);
        sample(1); sample(1);
        load_recover();
        sample(1);
        chk("R11 qualification restarted", int'(trip), 0);
        sample(1); sample(1);
        chk("R11 fresh qualification trips", int'(trip), 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule